// File: doc/BRIEF.md
# Serial Link Power State Tracker

This block follows the power state of one serial storage link from the host's side of the cable. The link sits in one of three live states: Active, Partial (shallow low power) or Slumber (deep low power). An Off state covers the time while the controller is in D3, and a Waking state covers a host-started wake. The host never moves the link into a low-power state by itself. It only acknowledges entry requests from the attached device.

When host logic needs the cable while the link is in Partial or Slumber, the block emits a one-cycle COM_WAKE strobe. It then holds link-ready low until the PHY side reports that the wake is complete. The device may also wake the link on its own. While the controller is in D3 the port counts as having no device, and nothing is held on it. After D3 the link comes back to Active only on a fresh link-up indication.

All request, wake and link-up inputs are sampled on the rising clock edge. Every output is a register, or is decoded from the state register, so each reaction shows one cycle after its cause.

Top module: `link_pm_tracker`

## Requirements
- R1: During and after reset, before any input takes effect, `pm_state` is Off (3'd0), `link_ready` is 0, and `req_ack` and `comwake` are 0. The state codes are Off=0, Active=1, Partial=2, Slumber=3, Waking=4.
- R2: In Active, a Partial or Slumber request moves `pm_state` to Partial or Slumber in the next cycle, and `req_ack` pulses in that same cycle. If both requests arrive together, Slumber is taken.
- R3: In Partial or Slumber, a device request with no wake condition present is acknowledged the next cycle, and the state moves to the requested low-power state. With no input active, the state holds.
- R4: In Partial or Slumber, `host_need` causes a one-cycle `comwake` pulse and the Waking state in the next cycle. Waking holds, with `link_ready` low, until `wake_done` is sampled. Active then follows in the next cycle.
- R5: In Partial or Slumber, `dev_wake` without `host_need` returns the state to Active in the next cycle, with no `comwake`.
- R6: While in Waking, device Partial and Slumber requests are ignored: no `req_ack` is given and the state does not change.
- R7: The host never enters a low-power state by itself. In Active, `host_need` and `dev_wake` change nothing, and no strobe is given.
- R8: `ctl_d3` high forces Off in the next cycle from any state. In that cycle `req_ack` and `comwake` are 0 and `link_ready` is 0.
- R9: Off is left only when `ctl_d3` is low and `link_up` is sampled high. The state then becomes Active in the next cycle. `link_ready` is 1 exactly when the state is Active.
- R10: In Partial or Slumber, the priority is `host_need` first, then `dev_wake`, then device requests. A request that is overridden in this way receives no `req_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_req_partial | input | 1 | Device asks to enter Partial |
| dev_req_slumber | input | 1 | Device asks to enter Slumber |
| dev_wake | input | 1 | Device has woken the link |
| host_need | input | 1 | A host operation needs the link |
| wake_done | input | 1 | PHY reports that the wake handshake finished |
| link_up | input | 1 | PHY reports a new link-up |
| ctl_d3 | input | 1 | Controller is in D3 |
| req_ack | output | 1 | One-cycle acknowledge of a device request |
| comwake | output | 1 | One-cycle strobe that starts the host wake signalling |
| pm_state | output | 3 | Current state code |
| link_ready | output | 1 | Link is usable (Active) |

## Verification
The state machine is driven with random mixes of requests, wakes, host demand, link-up and D3, at fixed seed. Each cycle is checked against a bench function that implements the requirements. Directed sequences then go through each path: Active to Partial and Slumber, a switch between the two low-power states, host wake with a long wait for completion, device wake, and a D3 entry and exit. These paths separate a host wake, which must strobe COM_WAKE, from a device wake, which must not. Simultaneous inputs then test the priority order and show that a request is dropped during a wake.

// File: rtl/link_pm_tracker.sv
module link_pm_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_req_partial,
  input  logic       dev_req_slumber,
  input  logic       dev_wake,
  input  logic       host_need,
  input  logic       wake_done,
  input  logic       link_up,
  input  logic       ctl_d3,
  output logic       req_ack,
  output logic       comwake,
  output logic [2:0] pm_state,
  output logic       link_ready
);
  localparam logic [2:0] ST_OFF   = 3'd0;
  localparam logic [2:0] ST_ACT   = 3'd1;
  localparam logic [2:0] ST_PART  = 3'd2;
  localparam logic [2:0] ST_SLUM  = 3'd3;
  localparam logic [2:0] ST_WAKE  = 3'd4;

  logic [2:0] st_q, st_d;
  logic       ack_d, cw_d;
  logic       any_req, low_pwr;
  logic [2:0] req_tgt;

  assign any_req = dev_req_partial | dev_req_slumber;
  assign req_tgt = dev_req_slumber ? ST_SLUM : ST_PART;
  assign low_pwr = (st_q == ST_PART) | (st_q == ST_SLUM);

  always_comb begin
    st_d  = st_q;
    ack_d = 1'b0;
    cw_d  = 1'b0;
    if (ctl_d3) begin
      st_d = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:  if (link_up) st_d = ST_ACT;
        ST_ACT:  if (any_req) begin st_d = req_tgt; ack_d = 1'b1; end
        ST_PART, ST_SLUM: begin
          if (host_need) begin
            st_d = ST_WAKE;
            cw_d = 1'b1;
          end else if (dev_wake) begin
            st_d = ST_ACT;
          end else if (any_req) begin
            st_d  = req_tgt;
            ack_d = 1'b1;
          end
        end
        ST_WAKE: if (wake_done) st_d = ST_ACT;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      req_ack <= 1'b0;
      comwake <= 1'b0;
    end else begin
      st_q    <= st_d;
      req_ack <= ack_d;
      comwake <= cw_d;
    end
  end

  assign pm_state   = st_q;
  assign link_ready = (st_q == ST_ACT);
  wire unused_ok = low_pwr;
endmodule

// File: rtl/link_pm_tracker_chk.sv
module link_pm_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_req_partial,
  input logic       dev_req_slumber,
  input logic       dev_wake,
  input logic       host_need,
  input logic       wake_done,
  input logic       link_up,
  input logic       ctl_d3,
  input logic       req_ack,
  input logic       comwake,
  input logic [2:0] pm_state,
  input logic       link_ready
);
  localparam logic [2:0] C_OFF  = 3'd0;
  localparam logic [2:0] C_ACT  = 3'd1;
  localparam logic [2:0] C_PART = 3'd2;
  localparam logic [2:0] C_SLUM = 3'd3;
  localparam logic [2:0] C_WAKE = 3'd4;

  // R2
  ack_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(dev_req_partial || dev_req_slumber));

  // R4
  comwake_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comwake |-> (pm_state == C_WAKE) && ($past(pm_state) == C_PART || $past(pm_state) == C_SLUM));

  // R4
  waking_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == C_WAKE) |-> !link_ready);

  // R6
  no_ack_in_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pm_state) == C_WAKE) |-> !req_ack);

  // R7
  no_host_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pm_state) == C_ACT) && (pm_state == C_PART || pm_state == C_SLUM)) |-> req_ack);

  // R8
  d3_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_d3) |-> (pm_state == C_OFF) && !req_ack && !comwake && !link_ready);

  // R9
  off_exit_needs_linkup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pm_state) == C_OFF) && (pm_state != C_OFF)) |-> $past(link_up) && (pm_state == C_ACT));

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && comwake));
endmodule

bind link_pm_tracker link_pm_tracker_chk u_chk (.*);

// File: tb/link_pm_tracker_bench.sv
module link_pm_tracker_bench;
  localparam logic [2:0] E_OFF  = 3'd0;
  localparam logic [2:0] E_ACT  = 3'd1;
  localparam logic [2:0] E_PART = 3'd2;
  localparam logic [2:0] E_SLUM = 3'd3;
  localparam logic [2:0] E_WAKE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pr = 0, ps = 0, dw = 0, hn = 0, wd = 0, lu = 0, d3 = 0;
  logic req_ack, comwake, link_ready;
  logic [2:0] pm_state;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [2:0] m_st = E_OFF;

  always #4 clk = ~clk;

  link_pm_tracker u_link_pm_tracker (
    .clk(clk), .rst_n(rst_n),
    .dev_req_partial(pr), .dev_req_slumber(ps), .dev_wake(dw),
    .host_need(hn), .wake_done(wd), .link_up(lu), .ctl_d3(d3),
    .req_ack(req_ack), .comwake(comwake), .pm_state(pm_state), .link_ready(link_ready)
  );

  typedef struct packed { logic [2:0] st; logic ack; logic cw; } exp_t;

  function automatic exp_t model(logic [2:0] s);
    exp_t e;
    e.st = s; e.ack = 0; e.cw = 0;
    if (d3) e.st = E_OFF;
    else if (s == E_OFF) begin if (lu) e.st = E_ACT; end
    else if (s == E_ACT) begin
      if (ps) begin e.st = E_SLUM; e.ack = 1; end
      else if (pr) begin e.st = E_PART; e.ack = 1; end
    end else if (s == E_PART || s == E_SLUM) begin
      if (hn) begin e.st = E_WAKE; e.cw = 1; end
      else if (dw) e.st = E_ACT;
      else if (ps) begin e.st = E_SLUM; e.ack = 1; end
      else if (pr) begin e.st = E_PART; e.ack = 1; end
    end else if (s == E_WAKE) begin if (wd) e.st = E_ACT; end
    return e;
  endfunction

  function automatic string tag_of(logic [2:0] s);
    if (d3) return "R8";
    if (s == E_OFF) return "R9";
    if (s == E_ACT) return (pr || ps) ? "R2" : "R7";
    if (s == E_WAKE) return (pr || ps) ? "R6" : "R4";
    if (hn && (dw || pr || ps)) return "R10";
    if (hn) return "R4";
    if (dw) return (pr || ps) ? "R10" : "R5";
    return "R3";
  endfunction

  task automatic check(string tag, logic [2:0] est, logic eack, logic ecw);
    logic erdy;
    erdy = (est == E_ACT);
    checks++;
    if (pm_state !== est || req_ack !== eack || comwake !== ecw || link_ready !== erdy) begin
      fails++;
      $display("FAIL %s: state=%0d ack=%0b cw=%0b rdy=%0b expected state=%0d ack=%0b cw=%0b rdy=%0b",
               tag, pm_state, req_ack, comwake, link_ready, est, eack, ecw, erdy);
    end
  endtask

  task automatic cyc(logic i_pr, logic i_ps, logic i_dw, logic i_hn, logic i_wd, logic i_lu, logic i_d3);
    exp_t e;
    string t;
    pr = i_pr; ps = i_ps; dw = i_dw; hn = i_hn; wd = i_wd; lu = i_lu; d3 = i_d3;
    e = model(m_st);
    t = tag_of(m_st);
    @(posedge clk);
    @(negedge clk);
    m_st = e.st;
    check(t, e.st, e.ack, e.cw);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // r1_ reset values while held in reset, with inputs toggling
    lu = 1; pr = 1; hn = 1;
    @(negedge clk);
    check("R1", E_OFF, 0, 0);
    pr = 0; hn = 0; lu = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1", E_OFF, 0, 0);

    // directed corner cases
    cyc(0,0,0,0,0,0,0);               // R9 stays off without link_up
    cyc(0,0,0,0,0,1,0);               // R9 link up -> active
    cyc(0,0,1,1,0,0,0);               // R7 host_need in active does nothing
    cyc(1,0,0,0,0,0,0);               // R2 enter partial
    cyc(0,1,0,0,0,0,0);               // R3 partial -> slumber with ack
    cyc(0,0,0,0,0,0,0);               // R3 hold
    cyc(1,0,1,1,0,0,0);               // R10 host wins
    cyc(1,1,0,0,0,0,0);               // R6 requests ignored in waking
    cyc(0,0,0,0,0,0,0);               // R4 still waking
    cyc(0,0,0,0,1,0,0);               // R4 wake done -> active
    cyc(1,1,0,0,0,0,0);               // R2 both -> slumber
    cyc(1,0,1,0,0,0,0);               // R10 device wake beats request
    cyc(1,0,0,0,0,0,0);               // R2 partial
    cyc(0,0,1,0,0,0,0);               // R5 device wake
    cyc(0,1,0,0,0,0,0);               // R2 slumber
    cyc(1,0,1,1,1,1,1);               // R8 d3 forces off
    cyc(0,0,0,0,0,0,1);               // R8 held
    cyc(0,0,0,0,0,1,1);               // R9 link_up ignored while in d3
    cyc(0,0,0,0,0,0,0);               // R9 still off
    cyc(0,0,0,0,0,1,0);               // R9 back to active

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 6) == 0, ($urandom % 7) == 0, ($urandom % 8) == 0,
          ($urandom % 5) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 40) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule